// File: doc/BRIEF.md
# PCM sample code formatter

This block converts audio samples between the 14-bit two's-complement form used inside a codec and the word that travels on the PCM serial port. It has a transmit path and a receive path. The transmit path takes an internal sample and produces the external code. The receive path takes an external code and returns an internal sample. Both paths share one set of mode inputs, and each has its own valid strobe.

In linear mode the external word has 14 bits. It can be in two's-complement, one's-complement or sign-magnitude form. In companded mode the external word is an 8-bit mu-255 code or A-law code, held in bits [7:0]. A-law can be used with or without inversion of its even bits. In a companded byte bit 7 is the first bit shifted on the line, and in a linear word bit 13 is the first.

A seven-bit option makes only the upper seven bits of a companded byte carry data. On transmit the LSB is driven as zero and flagged so that the serial port tri-states it. On receive the LSB is discarded. Both paths are registered, and each result appears one clock after its strobe.

Top module: `pcm_code_fmt`

## Requirements
- R1: During and right after reset, `tx_code` and `rx_smp` are zero, both output valid flags are low and `tx_lsb_en` is high.
- R2: `tx_out_vld` (`rx_out_vld`) is high exactly one cycle after `tx_vld` (`rx_vld`). Each result register changes only in the cycle after its own strobe and otherwise holds its value.
- R3: Linear transmit with `cfg_cmp`=0. Law 00 passes the sample unchanged. Law 01 gives one's-complement: a negative value is the bitwise inverse of its magnitude, with the magnitude saturated at 8191. Law 1x gives sign-magnitude: bit 13 is the sign and bits 12:0 hold the magnitude, saturated at 8191. Zero is always all zeros.
- R4: Linear receive decodes each of the three forms back to two's-complement. All-ones in one's-complement form decodes to zero.
- R5: Mu-255 transmit (`cfg_cmp`=1, law 1x) uses the following steps:
  - The magnitude is saturated at 8158 and then 33 is added.
  - The segment s (0..7) is the index of the highest set bit among bits 5..12, minus 5.
  - The mantissa is bits s+4..s+1 of the biased magnitude.
  - The code is the bitwise inverse of {negative, s, mantissa}.
  - Zero gives 0xFF.
- R6: Mu-255 receive inverts the byte to recover {sign, s, mantissa}. The magnitude is ((2*mantissa+33) << s) - 33, and it is negated when the sign bit is 1.
- R7: A-law transmit (`cfg_cmp`=1) uses the following steps:
  - m is half the sample magnitude, truncated and saturated at 4095.
  - The segment is 0 when m < 32. Otherwise it is the index of the highest set bit of m minus 4.
  - The mantissa is bits 4:1 of m for segment 0, and bits seg+3..seg of m for other segments.
  - The byte is {positive, seg, mantissa}.
  - Law 00 outputs this byte as is. Law 01 XORs it with 0x55.
- R8: A-law receive removes the 0x55 XOR under law 01. The 12-bit magnitude is 2*mantissa+1 for segment 0, or (2*mantissa+33) << (seg-1) for other segments. It is then doubled, and negated when bit 7 is 0.
- R9: With `cfg_cmp`=1 and `cfg_b7`=1, the transmitted code has bit 0 forced to 0 and `tx_lsb_en` low. On receive, bit 0 of `rx_code` has no effect on `rx_smp`.
- R10: In linear mode `cfg_b7` has no effect and `tx_lsb_en` is high. In companded mode `tx_code[13:8]` is zero, and `rx_code[13:8]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cmp | input | 1 | 0 selects linear, 1 selects companded |
| cfg_law | input | 2 | Number format or companding law |
| cfg_b7 | input | 1 | Seven-bit companded option |
| tx_vld | input | 1 | Transmit sample strobe |
| tx_smp | input | 14 | Internal two's-complement sample to send |
| rx_vld | input | 1 | Receive code strobe |
| rx_code | input | 14 | External code received (companded code in bits 7:0) |
| tx_out_vld | output | 1 | Transmit result valid |
| tx_code | output | 14 | External code to send |
| tx_lsb_en | output | 1 | Low when the code's LSB is to be tri-stated |
| rx_out_vld | output | 1 | Receive result valid |
| rx_smp | output | 14 | Decoded two's-complement sample |

## Verification
The transmit encode and the receive decode can both be requested in the same cycle, and they share the mode inputs. The bench raises both strobes together in every sweep step: a sample sweep runs on the transmit side while a code sweep runs on the receive side. Both results are then checked one cycle later against independent reference models, so a cross-coupling between the two paths appears as a mismatch on either output.

// File: rtl/pcm_code_fmt.sv
module pcm_code_fmt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_cmp,
  input  logic [1:0]  cfg_law,
  input  logic        cfg_b7,
  input  logic        tx_vld,
  input  logic [13:0] tx_smp,
  input  logic        rx_vld,
  input  logic [13:0] rx_code,
  output logic        tx_out_vld,
  output logic [13:0] tx_code,
  output logic        tx_lsb_en,
  output logic        rx_out_vld,
  output logic [13:0] rx_smp
);

  function automatic logic [7:0] mu_enc(input logic [13:0] x);
    logic [13:0] mag;
    logic [12:0] b;
    logic [2:0]  seg;
    mag = x[13] ? -x : x;
    if (mag > 14'd8158) mag = 14'd8158;
    b = 13'(mag + 14'd33);
    seg = '0;
    for (int i = 5; i <= 12; i++) if (b[i]) seg = 3'(i - 5);
    return ~{x[13], seg, 4'(b >> (32'(seg) + 1))};
  endfunction

  function automatic logic [13:0] mu_dec(input logic [7:0] c);
    logic [7:0]  p;
    logic [13:0] m;
    p = ~c;
    m = ({9'd0, p[3:0], 1'b0} + 14'd33) << p[6:4];
    m = m - 14'd33;
    return p[7] ? -m : m;
  endfunction

  function automatic logic [7:0] a_enc(input logic [13:0] x, input logic inv);
    logic [13:0] mag;
    logic [12:0] h;
    logic [11:0] m;
    logic [2:0]  seg;
    logic [3:0]  man;
    logic [7:0]  pre;
    mag = x[13] ? -x : x;
    h = 13'(mag >> 1);
    if (h > 13'd4095) h = 13'd4095;
    m = h[11:0];
    seg = '0;
    for (int i = 5; i <= 11; i++) if (m[i]) seg = 3'(i - 4);
    man = (seg == 3'd0) ? m[4:1] : 4'(m >> seg);
    pre = {~x[13], seg, man};
    return inv ? (pre ^ 8'h55) : pre;
  endfunction

  function automatic logic [13:0] a_dec(input logic [7:0] c, input logic inv);
    logic [7:0]  p;
    logic [12:0] m;
    logic [13:0] v;
    p = inv ? (c ^ 8'h55) : c;
    if (p[6:4] == 3'd0) m = {8'd0, p[3:0], 1'b1};
    else m = ({8'd0, p[3:0], 1'b1} + 13'd32) << (p[6:4] - 3'd1);
    v = {m, 1'b0};
    return p[7] ? v : -v;
  endfunction

  function automatic logic [13:0] lin_enc(input logic [13:0] x, input logic [1:0] law);
    logic [13:0] mag;
    mag = x[13] ? -x : x;
    if (mag > 14'd8191) mag = 14'd8191;
    if (!x[13] || law == 2'b00) return x;
    if (law == 2'b01) return ~mag;
    return {1'b1, mag[12:0]};
  endfunction

  function automatic logic [13:0] lin_dec(input logic [13:0] c, input logic [1:0] law);
    if (!c[13] || law == 2'b00) return c;
    if (law == 2'b01) return -(~c);
    return -{1'b0, c[12:0]};
  endfunction

  logic [7:0]  cmp_code, rx_byte;
  logic [13:0] tx_nxt, rx_nxt;

  assign cmp_code = cfg_law[1] ? mu_enc(tx_smp) : a_enc(tx_smp, cfg_law[0]);
  assign tx_nxt   = cfg_cmp ? {6'd0, cmp_code[7:1], cmp_code[0] & ~cfg_b7}
                            : lin_enc(tx_smp, cfg_law);
  assign rx_byte  = {rx_code[7:1], rx_code[0] & ~cfg_b7};
  assign rx_nxt   = !cfg_cmp   ? lin_dec(rx_code, cfg_law) :
                    cfg_law[1] ? mu_dec(rx_byte) : a_dec(rx_byte, cfg_law[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_out_vld <= 1'b0;
      rx_out_vld <= 1'b0;
      tx_code    <= '0;
      tx_lsb_en  <= 1'b1;
      rx_smp     <= '0;
    end else begin
      tx_out_vld <= tx_vld;
      rx_out_vld <= rx_vld;
      if (tx_vld) begin
        tx_code   <= tx_nxt;
        tx_lsb_en <= ~(cfg_cmp & cfg_b7);
      end
      if (rx_vld) rx_smp <= rx_nxt;
    end
  end

  // R2
  tx_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_vld |=> tx_out_vld);
  // R2
  rx_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_vld |=> rx_out_vld);
  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !tx_vld |=> $stable(tx_code) && !tx_out_vld);
  // R2
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !rx_vld |=> $stable(rx_smp) && !rx_out_vld);
  // R3
  lin_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && !cfg_cmp && tx_smp == 14'd0) |=> tx_code == 14'd0);
  // R9
  b7_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && cfg_cmp && cfg_b7) |=> (!tx_lsb_en && !tx_code[0]));
  // R10
  cmp_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && cfg_cmp) |=> tx_code[13:8] == 6'd0);
  // R10
  lin_lsb_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && !cfg_cmp) |=> tx_lsb_en);

endmodule

// File: tb/sim_pcm_code_fmt.sv
module sim_pcm_code_fmt;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cmp = 1'b0, cfg_b7 = 1'b0, tx_vld = 1'b0, rx_vld = 1'b0;
  logic [1:0] cfg_law = 2'b00;
  logic [13:0] tx_smp = '0, rx_code = '0;
  logic tx_out_vld, tx_lsb_en, rx_out_vld;
  logic [13:0] tx_code, rx_smp;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pcm_code_fmt u0 (.clk, .rst_n, .cfg_cmp, .cfg_law, .cfg_b7, .tx_vld, .tx_smp,
                   .rx_vld, .rx_code, .tx_out_vld, .tx_code, .tx_lsb_en,
                   .rx_out_vld, .rx_smp);

  function automatic int iabs(int x); return x < 0 ? -x : x; endfunction
  function automatic int sx14(logic [13:0] v); return int'($signed(v)); endfunction

  function automatic int r_lin_enc(int x, int law);
    int m = iabs(x) > 8191 ? 8191 : iabs(x);
    if (x >= 0 || law == 0) return x & 16383;
    if (law == 1) return (~m) & 16383;
    return 8192 | m;
  endfunction
  function automatic int r_lin_dec(int c, int law);
    if (c < 8192) return c;
    if (law == 0) return c - 16384;
    if (law == 1) return -((~c) & 16383);
    return -(c & 8191);
  endfunction
  function automatic int r_mu_enc(int x);
    int b = (iabs(x) > 8158 ? 8158 : iabs(x)) + 33;
    int seg = 0;
    while (seg < 7 && b >= (64 << seg)) seg++;
    return (~(((x < 0) << 7) | (seg << 4) | ((b >> (seg + 1)) & 15))) & 255;
  endfunction
  function automatic int r_mu_dec(int c);
    int p = (~c) & 255;
    int mag = (2 * (p & 15) + 33) * (1 << ((p >> 4) & 7)) - 33;
    return (p & 128) ? -mag : mag;
  endfunction
  function automatic int r_a_enc(int x, int inv);
    int m = iabs(x) / 2;
    int seg = 0, man, pre;
    if (m > 4095) m = 4095;
    if (m < 32) man = m >> 1;
    else begin
      seg = 1;
      while (seg < 7 && m >= (32 << seg)) seg++;
      man = (m >> seg) & 15;
    end
    pre = ((x < 0 ? 0 : 1) << 7) | (seg << 4) | man;
    return inv ? pre ^ 85 : pre;
  endfunction
  function automatic int r_a_dec(int c, int inv);
    int p = inv ? c ^ 85 : c;
    int seg = (p >> 4) & 7, man = p & 15, mag;
    mag = (seg == 0) ? 2 * man + 1 : (2 * man + 33) * (1 << (seg - 1));
    return (p & 128) ? 2 * mag : -2 * mag;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(logic cmp, logic [1:0] law, logic b7);
    @(negedge clk);
    cfg_cmp = cmp; cfg_law = law; cfg_b7 = b7;
  endtask

  task automatic step(int tx, int rx);
    @(negedge clk);
    tx_smp = 14'(tx); rx_code = 14'(rx); tx_vld = 1'b1; rx_vld = 1'b1;
    @(negedge clk);
    tx_vld = 1'b0; rx_vld = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 tx_code", int'(tx_code), 0);
    chk("R1 rx_smp", int'(rx_smp), 0);
    chk("R1 valids", int'({tx_out_vld, rx_out_vld}), 0);
    chk("R1 lsb_en", int'(tx_lsb_en), 1);
  endtask

  task automatic t_linear;
    for (int law = 0; law < 4; law++) begin
      cfg(1'b0, 2'(law), 1'b0);
      for (int x = -8192; x < 8192; x += 127) begin
        step(x, (x * 3) & 16383);
        chk("R3 lin tx", int'(tx_code), r_lin_enc(x, law));
        chk("R4 lin rx", sx14(rx_smp), r_lin_dec((x * 3) & 16383, law));
        chk("R2 vld", int'({tx_out_vld, rx_out_vld}), 3);
      end
      step(0, 16383);
      chk("R3 zero", int'(tx_code), 0);
      chk("R4 all ones", sx14(rx_smp), r_lin_dec(16383, law));
      step(-8192, 8192);
      chk("R3 min", int'(tx_code), r_lin_enc(-8192, law));
      chk("R4 neg zero", sx14(rx_smp), r_lin_dec(8192, law));
    end
  endtask

  task automatic t_mu;
    cfg(1'b1, 2'b10, 1'b0);
    step(0, 8'hFF);
    chk("R5 zero", int'(tx_code), 255);
    chk("R6 0xFF", sx14(rx_smp), 0);
    for (int i = 0; i < 256; i++) begin
      int x = (i * 64) - 8192 + (i % 7);
      step(x, 14'h2A00 | i);
      chk("R5 mu tx", int'(tx_code), r_mu_enc(x));
      chk("R6 mu rx", sx14(rx_smp), r_mu_dec(i));
    end
  endtask

  task automatic t_alaw;
    for (int inv = 0; inv < 2; inv++) begin
      cfg(1'b1, 2'(inv), 1'b0);
      step(0, inv ? 8'hD5 : 8'h80);
      chk("R7 zero", int'(tx_code), inv ? 8'hD5 : 8'h80);
      chk("R8 zero code", sx14(rx_smp), 2);
      for (int i = 0; i < 256; i++) begin
        int x = 8191 - (i * 64) - (i % 5);
        step(x, i);
        chk("R7 a tx", int'(tx_code), r_a_enc(x, inv));
        chk("R8 a rx", sx14(rx_smp), r_a_dec(i, inv));
      end
    end
  endtask

  task automatic t_b7;
    for (int law = 0; law < 3; law++) begin
      cfg(1'b1, 2'(law), 1'b1);
      for (int i = 0; i < 64; i++) begin
        int x = i * 251 - 8000;
        int c = (i * 37) & 255;
        int exp_rx = law == 2 ? r_mu_dec(c & 254) : r_a_dec(c & 254, law);
        step(x, c);
        chk("R9 tx lsb", int'(tx_code), (law == 2 ? r_mu_enc(x) : r_a_enc(x, law)) & 254);
        chk("R9 lsb_en", int'(tx_lsb_en), 0);
        chk("R9 rx lsb", sx14(rx_smp), exp_rx);
        step(x, c ^ 1);
        chk("R9 rx lsb flip", sx14(rx_smp), exp_rx);
      end
    end
    cfg(1'b0, 2'b10, 1'b1);
    step(-5, 14'h2003);
    chk("R10 lin b7 tx", int'(tx_code), r_lin_enc(-5, 2));
    chk("R10 lin b7 rx", sx14(rx_smp), -3);
    chk("R10 lin lsb_en", int'(tx_lsb_en), 1);
  endtask

  task automatic t_hold;
    logic [13:0] t0, r0;
    cfg(1'b0, 2'b00, 1'b0);
    step(1234, 4321);
    t0 = tx_code; r0 = rx_smp;
    tx_smp = 14'd77; rx_code = 14'd99; cfg_law = 2'b10;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 tx hold", int'(tx_code), int'(t0));
      chk("R2 rx hold", int'(rx_smp), int'(r0));
      chk("R2 vld low", int'({tx_out_vld, rx_out_vld}), 0);
    end
    @(negedge clk); tx_vld = 1'b1;
    @(negedge clk); tx_vld = 1'b0;
    chk("R2 tx only", int'(tx_code), r_lin_enc(77, 2));
    chk("R2 rx untouched", int'(rx_smp), int'(r0));
    chk("R2 vld split", int'({tx_out_vld, rx_out_vld}), 2);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_mu();
    t_alaw();
    t_b7();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule